// File: doc/BRIEF.md
# Multi-Input Trace Packet Merger

This block combines trace packet streams arriving from several upstream producers into one outgoing stream. The producers are per-core trace encoders or lower-level mergers of the same kind. Each input presents 32-bit words with valid/ready flow control and marks the first and last word of every packet. The block picks one input at a time with a rotating priority. Once an input is granted, every word of its packet passes through before any other input is served. The output therefore carries only whole, uninterleaved packets. When the downstream side deasserts ready, the granted input is held and waits; no word is lost and none is split.

Software reaches the block through a 4 KB window of 32-bit registers. The window holds a control word with an enable bit, a fixed identification word, a per-input mask that excludes inputs from arbitration, and a free-running 64-bit timestamp. The block drives the live timestamp value to the attached encoders so that trace from several cores can be correlated in time. A read of the timestamp's low word captures the high word, so that two 32-bit reads give one consistent 64-bit value.

Top module: `trace_funnel`

## Requirements
- R1: After reset, the control word, disable mask, timestamp control and timestamp count are all zero, no input sees ready and out_valid is low.
- R2: Offset 0x004 always reads 0x0000_1008: component type 0x8 in bits [3:0], minor version 0 in bits [11:8], major version 1 in bits [15:12]. Writes to it have no effect.
- R3: Any offset in the window other than 0x000, 0x004, 0x008, 0x040, 0x048 and 0x04C reads as zero, and writes to it change nothing readable.
- R4: At offset 0x008, bit i set to 1 excludes input i from arbitration; an excluded input is never granted. Bits at and above the input count read as zero.
- R5: Bit 0 of offset 0x000 enables arbitration. While it is 0, no new packet is granted.
- R6: Grants rotate round-robin among enabled inputs that have a valid word, starting at the input after the last one served. After reset, input 0 has the highest priority.
- R7: A grant takes one cycle to form after a request. It then lasts from the packet's start word to its end-marked word, so packets reach the output whole and are never interleaved.
- R8: Only the granted input sees in_ready, and only while out_ready is high. The output valid, data and start/end marks follow the granted input in the same cycle.
- R9: Bit 0 of offset 0x040 runs the timestamp. While it runs, the count rises by one on every clock edge and holds otherwise. ts_value shows the live count.
- R10: A read of offset 0x048 returns the low 32 count bits and captures the upper 32 bits. A read of 0x04C returns the captured upper bits. A write to 0x048 or 0x04C loads that half of the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset within the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| in_valid | input | N_IN | Per-input word valid |
| in_sop | input | N_IN | Per-input packet start mark |
| in_eop | input | N_IN | Per-input packet end mark |
| in_data | input | N_IN*DW | Per-input words, input i in bits [i*DW +: DW] |
| in_ready | output | N_IN | Per-input ready |
| out_valid | output | 1 | Merged stream valid |
| out_sop | output | 1 | Merged stream packet start |
| out_eop | output | 1 | Merged stream packet end |
| out_data | output | DW | Merged stream word |
| out_ready | input | 1 | Downstream ready |
| ts_value | output | TS_W | Live timestamp count to the encoders |

## Verification
A register write takes effect at the clock edge that ends its strobe cycle, and read data is combinational within the strobe cycle. The bench therefore samples read data one time unit after driving the strobe, and counts timestamp increments from the edge that latched the run bit. A pending input is granted at the first edge after its request appears, and its words then pass to the output combinationally in each cycle where out_ready is high. The stream checks compare each output word after the inputs settle, before the edge that completes the transfer. The timestamp coherence test counts edges exactly, so that the count crosses the 32-bit boundary between the low-word read and the high-word read. The captured and live upper halves are then known to differ.

// File: rtl/trace_funnel_pkg.sv
package trace_funnel_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_IDENT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_TSCTL = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_TSLO  = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_TSHI  = 12'h04C;

  localparam logic [3:0] COMP_TYPE = 4'h8;
  localparam logic [3:0] VER_MAJOR = 4'd1;
  localparam logic [3:0] VER_MINOR = 4'd0;
  localparam logic [31:0] IDENT_WORD = {16'h0000, VER_MAJOR, VER_MINOR, 4'h0, COMP_TYPE};
endpackage

// File: rtl/tf_rr_arbiter.sv
module tf_rr_arbiter #(
  parameter int N_IN = 4,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  req,
  input  logic [IDX_W-1:0] last,
  output logic             gnt_valid,
  output logic [IDX_W-1:0] gnt_idx
);
  int cand;

  // Scan from farthest to nearest so that the nearest requester after last wins.
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    cand      = 0;
    for (int k = N_IN; k >= 1; k--) begin
      cand = (int'(last) + k) % N_IN;
      if (req[cand]) begin
        gnt_valid = 1'b1;
        gnt_idx   = cand[IDX_W-1:0];
      end
    end
  end

  assert_pick_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req[gnt_idx]);
  assert_no_starve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> gnt_valid);
endmodule

// File: rtl/tf_timestamp.sv
module tf_timestamp #(
  parameter int TS_W = 64,
  localparam int HI_W = TS_W - 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [31:0]     wdata,
  output logic [TS_W-1:0] cnt
);
  logic [TS_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (ld_lo || ld_hi) begin
      if (ld_lo) cnt_n[31:0]      = wdata;
      if (ld_hi) cnt_n[TS_W-1:32] = wdata[HI_W-1:0];
    end else if (run) begin
      cnt_n = cnt_q + {{(TS_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

  assert_ts_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld_lo && !ld_hi) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_ts_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_lo && !ld_hi) |=> $stable(cnt_q));
endmodule

// File: rtl/tf_regs.sv
module tf_regs
  import trace_funnel_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int TS_W = 64,
  localparam int HI_W = TS_W - 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [TS_W-1:0]   ts_cnt,
  output logic              active,
  output logic [N_IN-1:0]   dis_mask,
  output logic              ts_run,
  output logic              ts_ld_lo,
  output logic              ts_ld_hi
);
  logic            active_q, active_n;
  logic [N_IN-1:0] mask_q, mask_n;
  logic            run_q, run_n;
  logic [HI_W-1:0] hi_cap_q, hi_cap_n;

  always_comb begin
    active_n = active_q;
    mask_n   = mask_q;
    run_n    = run_q;
    hi_cap_n = hi_cap_q;
    if (wr) begin
      case (addr)
        OFS_CTRL:  active_n = wdata[0];
        OFS_MASK:  mask_n   = wdata[N_IN-1:0];
        OFS_TSCTL: run_n    = wdata[0];
        default:   ;
      endcase
    end
    if (rd && (addr == OFS_TSLO)) hi_cap_n = ts_cnt[TS_W-1:32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mask_q   <= '0;
      run_q    <= 1'b0;
      hi_cap_q <= '0;
    end else begin
      active_q <= active_n;
      mask_q   <= mask_n;
      run_q    <= run_n;
      hi_cap_q <= hi_cap_n;
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL:  rdata = {31'b0, active_q};
      OFS_IDENT: rdata = IDENT_WORD;
      OFS_MASK:  rdata = 32'(mask_q);
      OFS_TSCTL: rdata = {31'b0, run_q};
      OFS_TSLO:  rdata = ts_cnt[31:0];
      OFS_TSHI:  rdata = 32'(hi_cap_q);
      default:   rdata = '0;
    endcase
  end

  assign active   = active_q;
  assign dis_mask = mask_q;
  assign ts_run   = run_q;
  assign ts_ld_lo = wr && (addr == OFS_TSLO);
  assign ts_ld_hi = wr && (addr == OFS_TSHI);

  assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == OFS_TSLO) |=> (hi_cap_q == $past(ts_cnt[TS_W-1:32])));
  assert_capture_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && addr == OFS_TSLO) |=> $stable(hi_cap_q));
endmodule

// File: rtl/trace_funnel.sv
module trace_funnel
  import trace_funnel_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int DW   = 32,
  parameter int TS_W = 64,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [N_IN-1:0]      in_valid,
  input  logic [N_IN-1:0]      in_sop,
  input  logic [N_IN-1:0]      in_eop,
  input  logic [N_IN*DW-1:0]   in_data,
  output logic [N_IN-1:0]      in_ready,
  output logic                 out_valid,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic [DW-1:0]        out_data,
  input  logic                 out_ready,
  output logic [TS_W-1:0]      ts_value
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic            active, ts_run, ts_ld_lo, ts_ld_hi;
  logic [N_IN-1:0] dis_mask;

  tf_regs #(.N_IN(N_IN), .TS_W(TS_W)) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .ts_cnt   (ts_value),
    .active   (active),
    .dis_mask (dis_mask),
    .ts_run   (ts_run),
    .ts_ld_lo (ts_ld_lo),
    .ts_ld_hi (ts_ld_hi)
  );

  tf_timestamp #(.TS_W(TS_W)) u_ts (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (ts_run),
    .ld_lo (ts_ld_lo),
    .ld_hi (ts_ld_hi),
    .wdata (reg_wdata),
    .cnt   (ts_value)
  );

  // Grant state
  logic             locked_q, locked_n;
  logic [IDX_W-1:0] owner_q, owner_n;
  logic [IDX_W-1:0] last_q, last_n;
  logic [N_IN-1:0]  req;
  logic             arb_valid;
  logic [IDX_W-1:0] arb_idx;
  logic             beat_fire;

  assign req = active ? (in_valid & ~dis_mask) : '0;

  tf_rr_arbiter #(.N_IN(N_IN)) u_arb (
    .clk       (clk),
    .rst_n     (srst_n),
    .req       (req),
    .last      (last_q),
    .gnt_valid (arb_valid),
    .gnt_idx   (arb_idx)
  );

  logic [DW-1:0] in_word [N_IN];

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    assign in_word[g]  = in_data[g*DW +: DW];
    assign in_ready[g] = locked_q && (owner_q == IDX_W'(g)) && out_ready;
  end

  assign out_valid = locked_q && in_valid[owner_q];
  assign out_sop   = locked_q && in_sop[owner_q];
  assign out_eop   = locked_q && in_eop[owner_q];
  assign out_data  = in_word[owner_q];
  assign beat_fire = out_valid && out_ready;

  always_comb begin
    locked_n = locked_q;
    owner_n  = owner_q;
    last_n   = last_q;
    if (!locked_q) begin
      if (arb_valid) begin
        locked_n = 1'b1;
        owner_n  = arb_idx;
      end
    end else if (beat_fire && in_eop[owner_q]) begin
      locked_n = 1'b0;
      last_n   = owner_q;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      last_q   <= IDX_W'(N_IN - 1);
    end else begin
      locked_q <= locked_n;
      owner_q  <= owner_n;
      last_q   <= last_n;
    end
  end

  assert_ready_onehot_R8: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(in_ready));
  assert_ready_needs_out_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (|in_ready) |-> out_ready);
  assert_hold_grant_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (locked_q && !(beat_fire && out_eop)) |=> (locked_q && $stable(owner_q)));
  assert_grant_enabled_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (!locked_q && arb_valid) |-> !dis_mask[arb_idx]);
  assert_inactive_no_grant_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (!active && !locked_q) |=> !locked_q);
endmodule

// File: tb/tb_trace_funnel.sv
module tb_trace_funnel;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            reg_wr, reg_rd;
  logic [11:0]     reg_addr;
  logic [31:0]     reg_wdata, reg_rdata;
  logic [N-1:0]    in_valid, in_sop, in_eop, in_ready;
  logic [N*DW-1:0] in_data;
  logic            out_valid, out_sop, out_eop, out_ready;
  logic [DW-1:0]   out_data;
  logic [63:0]     ts_value;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_funnel dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data), .out_ready(out_ready),
    .ts_value(ts_value)
  );

  typedef struct packed {
    logic        act;
    logic        stall;
    logic [3:0]  dis;
    logic [3:0]  len;
    logic [7:0]  cnt;   // packets per input, 2 bits each, input 0 in [1:0]
    logic [3:0]  nexp;
    logic [31:0] ord;   // expected grant order, first packet in [3:0]
  } scen_t;

  localparam int NSCN = 7;
  localparam scen_t SCN [NSCN] = '{
    '{1'b1, 1'b0, 4'h0, 4'd3, 8'h55, 4'd4, 32'h0000_3210},
    '{1'b1, 1'b0, 4'h0, 4'd2, 8'h44, 4'd2, 32'h0000_0031},
    '{1'b1, 1'b0, 4'h5, 4'd2, 8'h55, 4'd2, 32'h0000_0031},
    '{1'b1, 1'b1, 4'h0, 4'd4, 8'h55, 4'd4, 32'h0000_3210},
    '{1'b1, 1'b0, 4'h0, 4'd1, 8'h46, 4'd4, 32'h0000_0310},
    '{1'b0, 1'b0, 4'h0, 4'd2, 8'h55, 4'd0, 32'h0000_0000},
    '{1'b1, 1'b0, 4'h8, 4'd1, 8'hAA, 4'd6, 32'h0021_0210}
  };

  int n_chk = 0, n_fail = 0;
  int pend [N];
  int beat [N];
  int pkt  [N];
  int cur_len, cyc;
  int got_n, integ_err, rdy_err;
  logic [31:0] got_ord;
  bit open;
  int open_id, exp_bt;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = '0; in_sop = '0; in_eop = '0; in_data = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    out_ready = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [11:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // One stream cycle: drive at negedge, observe settled values, account the coming edge.
  task automatic step(bit stall);
    int id, bt;
    for (int i = 0; i < N; i++) begin
      in_valid[i] = (pend[i] != 0);
      in_sop[i]   = (beat[i] == 0);
      in_eop[i]   = (beat[i] == cur_len - 1);
      in_data[i*DW +: DW] = {8'(i), 8'(pkt[i]), 16'(beat[i])};
    end
    out_ready = stall ? cyc[0] : 1'b1;
    #1;
    if ((in_ready & (in_ready - 1'b1)) != 0) rdy_err++;
    if ((in_ready != 0) && !out_ready) rdy_err++;
    if (out_valid && out_ready) begin
      id = int'(out_data[31:24]);
      bt = int'(out_data[15:0]);
      if (id >= N || !in_ready[id]) integ_err++;
      if (out_sop) begin
        if (open || bt != 0) integ_err++;
        open = 1'b1; open_id = id; exp_bt = 1;
        got_ord = got_ord | (32'(id) << (4*got_n));
        got_n++;
      end else begin
        if (!open || id != open_id || bt != exp_bt) integ_err++;
        exp_bt = bt + 1;
      end
      if (out_eop) begin
        if (bt != cur_len - 1) integ_err++;
        open = 1'b0;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (in_valid[i] && in_ready[i]) begin
        if (beat[i] == cur_len - 1) begin
          beat[i] = 0; pkt[i]++; pend[i]--;
        end else begin
          beat[i]++;
        end
      end
    end
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1: reset state
    rd_reg(12'h000, d); chk(d == 32'h0, "R1 ctrl", d, 0);
    rd_reg(12'h008, d); chk(d == 32'h0, "R1 mask", d, 0);
    rd_reg(12'h040, d); chk(d == 32'h0, "R1 tsctl", d, 0);
    rd_reg(12'h048, d); chk(d == 32'h0, "R1 tslo", d, 0);
    in_valid = 4'hF; in_sop = 4'hF; #1;
    chk(in_ready == 4'h0 && out_valid == 1'b0, "R1 stream idle", {in_ready, out_valid}, 0);
    @(negedge clk); idle_inputs();

    // R2: identification word
    rd_reg(12'h004, d); chk(d == 32'h0000_1008, "R2 ident", d, 32'h1008);
    wr_reg(12'h004, 32'h0);
    rd_reg(12'h004, d); chk(d == 32'h0000_1008, "R2 ident after write", d, 32'h1008);

    // R3: unimplemented offsets
    rd_reg(12'h00C, d); chk(d == 32'h0, "R3 0x00C", d, 0);
    rd_reg(12'h044, d); chk(d == 32'h0, "R3 0x044", d, 0);
    wr_reg(12'h010, 32'hFFFF_FFFF);
    rd_reg(12'h010, d); chk(d == 32'h0, "R3 0x010 after write", d, 0);
    wr_reg(12'hFFC, 32'hFFFF_FFFF);
    rd_reg(12'hFFC, d); chk(d == 32'h0, "R3 0xFFC after write", d, 0);

    // R4: mask width
    wr_reg(12'h008, 32'hFFFF_FFFF);
    rd_reg(12'h008, d); chk(d == 32'h0000_000F, "R4 mask width", d, 32'hF);
    rd_reg(12'h000, d); chk(d == 32'h0, "R3 ctrl untouched", d, 0);

    // R9, R10: timestamp runs from the edge after the run bit is latched
    wr_reg(12'h040, 32'h1);
    repeat (10) @(negedge clk);
    rd_reg(12'h048, d); chk(d == 32'd10, "R9 count after 10 edges", d, 10);
    rd_reg(12'h04C, d); chk(d == 32'd0, "R10 captured high zero", d, 0);
    wr_reg(12'h040, 32'h0);
    wr_reg(12'h04C, 32'h5);
    wr_reg(12'h048, 32'hFFFF_FFF0);
    repeat (3) @(negedge clk);
    rd_reg(12'h048, d); chk(d == 32'hFFFF_FFF0, "R9 hold while stopped", d, 32'hFFFF_FFF0);
    wr_reg(12'h040, 32'h1);
    repeat (13) @(negedge clk);
    rd_reg(12'h048, d); chk(d == 32'hFFFF_FFFD, "R10 low word", d, 32'hFFFF_FFFD);
    repeat (5) @(negedge clk);
    #1 chk(ts_value == 64'h6_0000_0003, "R9 live ts_value", ts_value, 64'h6_0000_0003);
    @(negedge clk);
    rd_reg(12'h04C, d); chk(d == 32'h5, "R10 coherent high", d, 5);
    rd_reg(12'h048, d); chk(d == 32'h0000_0005, "R10 low after wrap", d, 5);
    rd_reg(12'h04C, d); chk(d == 32'h6, "R10 new high", d, 6);

    // Stream scenarios from the table: R4 R5 R6 R7 R8
    for (int s = 0; s < NSCN; s++) begin
      do_reset();
      wr_reg(12'h008, 32'(SCN[s].dis));
      wr_reg(12'h000, 32'(SCN[s].act));
      cur_len = int'(SCN[s].len);
      for (int i = 0; i < N; i++) begin
        pend[i] = int'((SCN[s].cnt >> (2*i)) & 8'h3);
        beat[i] = 0; pkt[i] = 0;
      end
      cyc = 0; got_n = 0; got_ord = '0; integ_err = 0; rdy_err = 0; open = 1'b0;
      for (int c = 0; c < 80; c++) step(SCN[s].stall);
      idle_inputs(); out_ready = 1'b1;
      chk(got_n == int'(SCN[s].nexp), $sformatf("R5 R4 packet count s%0d", s), got_n, SCN[s].nexp);
      chk(got_ord == SCN[s].ord, $sformatf("R6 grant order s%0d", s), got_ord, SCN[s].ord);
      chk(integ_err == 0 && !open, $sformatf("R7 whole packets s%0d", s), integ_err, 0);
      chk(rdy_err == 0, $sformatf("R8 ready rules s%0d", s), rdy_err, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule